// File: doc/BRIEF.md
# Indirect MAC Configuration Register Bridge

This block lets a host reach a small bank of MAC configuration registers without mapping them onto the bus. The host sees only two words: a command word and a data word, picked by a select input. To start an internal access, the host writes a command word with its start flag set. The word also carries a direction flag and a register index. The bridge then reports busy for a fixed number of cycles and performs the access when that time has run out.

For a write, the host loads the data word first and then issues the command. The value committed is the data word present when the command is accepted. For a read, the selected register is copied into the data word in the same cycle that busy drops, so the host polls busy and then reads the data word.

The bank holds a MAC control register and a 48-bit station address made of a 32-bit low part and a 16-bit high part. The remaining indices, which include the MII access and data slots, are general 32-bit storage. The transmit and receive enables and the station address are also driven straight out to the MAC datapath.

Top module: `mac_csr_bridge`

## Requirements
- R1: After a synchronous active-high reset, the command word, the data word, every bank register, both enables and the station address read zero.
- R2: Command word layout: bit 31 is the start/busy flag, bit 30 selects read (1) or write (0), and bits 3:0 hold the register index. A command is accepted when bit 31 is 1, the index is 12 or less and the bridge is idle. Once accepted, bit 31 of the command word reads 1.
- R3: After a command is accepted, busy reads 1 for exactly 4 clock cycles and then returns to 0.
- R4: A write command stores into the indexed register the data word held at acceptance. The stored value is visible when busy clears.
- R5: A read command copies the indexed register into the data word in the cycle busy returns to 0.
- R6: A command whose index is 13, 14 or 15 is ignored. Busy stays 0 and no register or output changes.
- R7: A command written while busy is 1 is ignored. The index and direction of the operation in progress, and its result, are unchanged.
- R8: A data word write while busy is 1 is ignored.
- R9: Index 1 is the MAC control register. Bit 0 drives the transmit enable and bit 1 drives the receive enable. The two bits are independent.
- R10: Index 2 holds station address bytes 0 to 3 (byte 0 in bits 7:0). Index 3 holds bytes 4 and 5 in bits 15:0, and its upper 16 bits always read 0. The station address output is {index3[15:0], index2}.
- R11: Index 0 always reads 0, and writes to it have no effect.
- R12: A command word written with bit 31 clear starts nothing, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWrEn | input | 1 | Host write strobe, one cycle per write |
| hostSel | input | 1 | 0 selects the command word, 1 selects the data word |
| hostWrData | input | 32 | Host write value |
| cmdRdData | output | 32 | Command word readback: busy, direction, index |
| dataRdData | output | 32 | Data word readback |
| txEnable | output | 1 | Transmit enable from the control register |
| rxEnable | output | 1 | Receive enable from the control register |
| stationAddr | output | 48 | Station address, byte 0 in bits 7:0 |

## Verification
The bench sweeps every legal index with a distinct write value, then reads each index back. This separates correct index decoding from aliasing, and it exposes the zero register and the masked high address half. It counts busy cycles on every command, so an off-by-one latency shows up.

Separate patterns cover three more cases. Out-of-range indices and commands without the start flag must change nothing. Commands and data writes issued in the middle of an operation must not change its target or its value. Control register values that set either enable alone show whether the two bits are swapped or tied together.

// File: rtl/mac_csr_pkg.sv
package mac_csr_pkg;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 4;
  localparam int BUSY_BIT = 31;
  localparam int RD_BIT   = 30;

  // bank slots with dedicated behaviour
  localparam int IDX_ZERO    = 0;
  localparam int IDX_CTRL    = 1;
  localparam int IDX_ADDR_LO = 2;
  localparam int IDX_ADDR_HI = 3;
  localparam int HI_W        = 16;

  localparam int CTRL_TX_BIT = 0;
  localparam int CTRL_RX_BIT = 1;

  typedef struct packed {
    logic             busy;
    logic             finish;
    logic             isRead;
    logic [IDX_W-1:0] index;
  } csrStrobe_t;
endpackage

// File: rtl/mac_csr_ctrl.sv
module mac_csr_ctrl
  import mac_csr_pkg::*;
#(
  parameter int NUM_REGS = 13,
  parameter int LATENCY  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdWrEn,
  input  logic [DATA_W-1:0] cmdWord,
  output csrStrobe_t        strb
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [IDX_W:0] LAST_IDX = (IDX_W+1)'(NUM_REGS - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             isRead;
  logic [IDX_W-1:0] idx;
  logic             idxOk;
  logic             accept;
  logic             finish;

  assign idxOk  = ({1'b0, cmdWord[IDX_W-1:0]} <= LAST_IDX);
  assign accept = cmdWrEn && cmdWord[BUSY_BIT] && idxOk && !busy;
  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      isRead <= 1'b0;
      idx    <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= CNT_W'(LATENCY - 1);
      isRead <= cmdWord[RD_BIT];
      idx    <= cmdWord[IDX_W-1:0];
    end else if (finish) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign strb.busy   = busy;
  assign strb.finish = finish;
  assign strb.isRead = isRead;
  assign strb.index  = idx;

  // independent busy-run counter used by the latency checks
  logic [CNT_W:0] runCnt;
  always_ff @(posedge clk) begin
    if (rst)       runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
    else           runCnt <= '0;
  end

  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (cmdWrEn && cmdWord[BUSY_BIT] && idxOk && !busy) |=> busy);

  assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (runCnt < (CNT_W+1)'(LATENCY)));

  assert_busy_length_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(runCnt) == (CNT_W+1)'(LATENCY - 1)));

  assert_bad_index_R6: assert property (@(posedge clk) disable iff (rst)
    (cmdWrEn && !idxOk && !busy) |=> !busy);

  assert_no_start_R12: assert property (@(posedge clk) disable iff (rst)
    (cmdWrEn && !cmdWord[BUSY_BIT] && !busy) |=> !busy);

  assert_op_locked_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || ($stable(idx) && $stable(isRead))));
endmodule

// File: rtl/mac_csr_dp.sv
module mac_csr_dp
  import mac_csr_pkg::*;
#(
  parameter int NUM_REGS = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dataWrEn,
  input  logic [DATA_W-1:0] dataWrWord,
  input  csrStrobe_t        strb,
  output logic [DATA_W-1:0] dataReg,
  output logic              txEnable,
  output logic              rxEnable,
  output logic [DATA_W+HI_W-1:0] stationAddr
);
  logic [DATA_W-1:0] bankQ [NUM_REGS];
  logic [DATA_W-1:0] rdMux;
  logic              commit;

  assign commit = strb.finish && !strb.isRead;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSlot
    if (g == IDX_ZERO) begin : gZero
      assign bankQ[g] = '0;
    end else begin : gStore
      localparam logic [DATA_W-1:0] KEEP =
        (g == IDX_ADDR_HI) ? {{(DATA_W-HI_W){1'b0}}, {HI_W{1'b1}}} : '1;
      always_ff @(posedge clk) begin
        if (rst)
          bankQ[g] <= '0;
        else if (commit && (strb.index == IDX_W'(g)))
          bankQ[g] <= dataReg & KEEP;
      end
    end
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (strb.index == IDX_W'(i)) rdMux = bankQ[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      dataReg <= '0;
    else if (strb.finish && strb.isRead)
      dataReg <= rdMux;
    else if (dataWrEn && !strb.busy)
      dataReg <= dataWrWord;
  end

  assign txEnable    = bankQ[IDX_CTRL][CTRL_TX_BIT];
  assign rxEnable    = bankQ[IDX_CTRL][CTRL_RX_BIT];
  assign stationAddr = {bankQ[IDX_ADDR_HI][HI_W-1:0], bankQ[IDX_ADDR_LO]};

  assert_data_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (strb.busy && !strb.finish) |=> $stable(dataReg));

  assert_ctrl_commit_R9: assert property (@(posedge clk) disable iff (rst)
    (commit && strb.index == IDX_W'(IDX_CTRL)) |=>
      (txEnable == $past(dataReg[CTRL_TX_BIT]) && rxEnable == $past(dataReg[CTRL_RX_BIT])));

  assert_addr_commit_R10: assert property (@(posedge clk) disable iff (rst)
    (commit && strb.index == IDX_W'(IDX_ADDR_HI)) |=>
      (stationAddr[DATA_W+HI_W-1:DATA_W] == $past(dataReg[HI_W-1:0])));

  assert_idle_outputs_R4: assert property (@(posedge clk) disable iff (rst)
    !strb.busy |=> ($stable(txEnable) && $stable(rxEnable) && $stable(stationAddr)));
endmodule

// File: rtl/mac_csr_bridge.sv
module mac_csr_bridge
  import mac_csr_pkg::*;
#(
  parameter int NUM_REGS = 13,
  parameter int LATENCY  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hostWrEn,
  input  logic        hostSel,
  input  logic [31:0] hostWrData,
  output logic [31:0] cmdRdData,
  output logic [31:0] dataRdData,
  output logic        txEnable,
  output logic        rxEnable,
  output logic [47:0] stationAddr
);
  csrStrobe_t strb;

  mac_csr_ctrl #(.NUM_REGS(NUM_REGS), .LATENCY(LATENCY)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .cmdWrEn (hostWrEn && !hostSel),
    .cmdWord (hostWrData),
    .strb    (strb)
  );

  mac_csr_dp #(.NUM_REGS(NUM_REGS)) uDp (
    .clk         (clk),
    .rst         (rst),
    .dataWrEn    (hostWrEn && hostSel),
    .dataWrWord  (hostWrData),
    .strb        (strb),
    .dataReg     (dataRdData),
    .txEnable    (txEnable),
    .rxEnable    (rxEnable),
    .stationAddr (stationAddr)
  );

  assign cmdRdData = {strb.busy, strb.isRead, {(DATA_W-2-IDX_W){1'b0}}, strb.index};
endmodule

// File: tb/tb_mac_csr_bridge.sv
module tb_mac_csr_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostWrEn = 1'b0;
  logic        hostSel = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] cmdRdData, dataRdData;
  logic        txEnable, rxEnable;
  logic [47:0] stationAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mac_csr_bridge dut (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .cmdRdData(cmdRdData), .dataRdData(dataRdData),
    .txEnable(txEnable), .rxEnable(rxEnable), .stationAddr(stationAddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdWord(input bit start, input bit rd, input int idx);
    return {start, rd, 26'b0, 4'(idx)};
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE0000 | (32'(i) << 8) | 32'(i * 7);
  endfunction

  task automatic hostWr(input logic sel, input logic [31:0] w);
    hostSel = sel; hostWrData = w; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (cmdRdData[31] && n < 50) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic regWrite(input int idx, input logic [31:0] v);
    int n;
    hostWr(1'b1, v);
    hostWr(1'b0, cmdWord(1'b1, 1'b0, idx));
    waitIdle(n);
    chk(n == 4, "R3 write busy cycles", 48'(n), 48'd4);
  endtask

  task automatic regRead(input int idx, output logic [31:0] v);
    int n;
    hostWr(1'b0, cmdWord(1'b1, 1'b1, idx));
    waitIdle(n);
    chk(n == 4, "R3 read busy cycles", 48'(n), 48'd4);
    v = dataRdData;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v, exp;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(cmdRdData == 0, "R1 cmd", 48'(cmdRdData), 0);
    chk(dataRdData == 0, "R1 data", 48'(dataRdData), 0);
    chk(!txEnable && !rxEnable, "R1 enables", {46'b0, rxEnable, txEnable}, 0);
    chk(stationAddr == 0, "R1 station", stationAddr, 0);
    regRead(5, v);
    chk(v == 0, "R1 bank zero", 48'(v), 0);

    // R2: busy seen right after acceptance
    hostWr(1'b1, 32'h1234_5678);
    hostWr(1'b0, cmdWord(1'b1, 1'b0, 7));
    chk(cmdRdData == 32'h8000_0007, "R2 cmd readback", 48'(cmdRdData), 48'h8000_0007);
    waitIdle(n);
    chk(n == 4, "R3 busy cycles", 48'(n), 48'd4);

    // R4 sweep of writes
    for (int i = 0; i < 13; i++) regWrite(i, pat(i));
    // R4/R5/R10/R11 readback
    for (int i = 0; i < 13; i++) begin
      regRead(i, v);
      exp = (i == 0) ? 32'h0 : (i == 3) ? (pat(i) & 32'h0000_FFFF) : pat(i);
      chk(v == exp, (i == 0) ? "R11 zero slot" : (i == 3) ? "R10 high mask" : "R5 readback",
          48'(v), 48'(exp));
    end

    // R9 control bits
    regWrite(1, 32'h1);
    chk(txEnable && !rxEnable, "R9 tx only", {46'b0, rxEnable, txEnable}, 48'd1);
    regWrite(1, 32'h2);
    chk(!txEnable && rxEnable, "R9 rx only", {46'b0, rxEnable, txEnable}, 48'd2);

    // R10 station address
    regWrite(2, 32'h4433_2211);
    regWrite(3, 32'hFFFF_6655);
    chk(stationAddr == 48'h6655_4433_2211, "R10 station", stationAddr, 48'h6655_4433_2211);

    // R6 bad indices
    for (int i = 13; i < 16; i++) begin
      hostWr(1'b1, 32'hDEAD_0000 | 32'(i));
      hostWr(1'b0, cmdWord(1'b1, 1'b0, i));
      chk(cmdRdData[31] == 1'b0, "R6 busy stays low", 48'(cmdRdData), 0);
      hostWr(1'b0, cmdWord(1'b1, 1'b1, i));
      chk(dataRdData == (32'hDEAD_0000 | 32'(i)), "R6 data unchanged",
          48'(dataRdData), 48'(32'hDEAD_0000 | 32'(i)));
    end
    chk(stationAddr == 48'h6655_4433_2211, "R6 station kept", stationAddr, 48'h6655_4433_2211);
    chk(!txEnable && rxEnable, "R6 enables kept", {46'b0, rxEnable, txEnable}, 48'd2);

    // R12 command without start flag
    hostWr(1'b1, 32'h0BAD_F00D);
    hostWr(1'b0, cmdWord(1'b0, 1'b1, 2));
    chk(cmdRdData[31] == 1'b0, "R12 no busy", 48'(cmdRdData), 0);
    @(negedge clk);
    chk(dataRdData == 32'h0BAD_F00D, "R12 data kept", 48'(dataRdData), 48'h0BAD_F00D);

    // R7 command during busy
    hostWr(1'b1, 32'h5555_AAAA);
    hostWr(1'b0, cmdWord(1'b1, 1'b0, 5));
    hostWr(1'b0, cmdWord(1'b1, 1'b1, 2));
    chk(cmdRdData == 32'h8000_0005, "R7 op locked", 48'(cmdRdData), 48'h8000_0005);
    waitIdle(n);
    chk(n == 3, "R7 busy not restarted", 48'(n), 48'd3);
    regRead(5, v);
    chk(v == 32'h5555_AAAA, "R7 result", 48'(v), 48'h5555_AAAA);

    // R8 data write during busy
    hostWr(1'b1, 32'h1111_2222);
    hostWr(1'b0, cmdWord(1'b1, 1'b0, 6));
    hostWr(1'b1, 32'h3333_4444);
    waitIdle(n);
    chk(dataRdData == 32'h1111_2222, "R8 data kept", 48'(dataRdData), 48'h1111_2222);
    regRead(6, v);
    chk(v == 32'h1111_2222, "R8 committed value", 48'(v), 48'h1111_2222);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule